// File: doc/BRIEF.md
# In-Order Retirement Buffer

This block keeps every in-flight micro-operation in program order, in a circular array addressed by a head pointer and a tail pointer. The rename stage writes one new entry per cycle. Each entry holds the operation's PC, its op class, the physical register it writes, and the physical register that the same architectural register was mapped to before it. Execution units later mark an entry complete by its index, optionally with a fault. The head of the buffer then commits in order, up to two entries per cycle. For each committed entry, its older (stale) physical register is handed to the free list.

Two events cut the buffer back. A branch misprediction names the tag of the branch. Every entry younger than that branch is discarded, and the physical registers those entries had newly claimed are returned, youngest first. A fault found at the head is reported once, with that entry's PC and op class. The faulting entry is not committed. It and every younger entry are then discarded the same way. Discarding walks back from the tail at up to two entries per cycle. While it runs, new allocation and commit are both held off.

Top module: `retire_queue`

## Requirements
- R1: After reset the buffer is empty (`empty`=1, `full`=0), `al_ready` is 1, and `rt_valid`, `sq_valid` and `ex_valid` are all 0.
- R2: Entries are allocated one per cycle in program order. `al_tag` shows the tag the next entry receives: the tail pointer, with bits [3:0] as the slot index and bit 4 as a wrap bit. The tag increments by one per accepted allocation. `al_ready` is 0 when the free slot count is below one, and an allocation offered then leaves `al_tag` unchanged.
- R3: An entry commits only when it is at the head, has been marked complete, and carries no fault. Commits follow allocation order. Each commit presents that entry's stale physical register on `rt_old`.
- R4: Up to two entries commit per cycle. Slot 0 of `rt_valid`/`rt_old` (bits [6:0] of `rt_old`) is the head entry, and slot 1 (bits [13:7]) is the entry after it. Slot 1 is valid only when slot 0 is valid in the same cycle.
- R5: When the head entry is complete with a fault, `ex_valid` is 1 for one cycle with that entry's PC and op class, and nothing commits. From the next cycle, that entry and all younger entries are discarded: their destination registers appear on `sq_dst`, youngest first, two per cycle. The buffer ends empty.
- R6: A misprediction with tag T keeps entry T and everything older, and discards every younger entry. Their destination registers appear on `sq_dst`, youngest first, up to two per cycle. Slot 0 of `sq_valid`/`sq_dst` (bits [6:0]) is the youngest remaining entry. No commit happens in the cycle the misprediction is presented, and no allocation is accepted until the discard finishes.
- R7: `full` is 1 exactly when 16 entries are held and `empty` exactly when none are held. The wrap bit keeps the two cases apart across pointer wrap-around.
- R8: Completion marks the entry at `cp_idx`, in any order. A completed entry behind an incomplete head does not commit.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| al_valid | input | 1 | Rename offers a new entry |
| al_ready | output | 1 | Buffer accepts the offered entry this cycle |
| al_pc | input | 32 | PC of the new micro-operation |
| al_op | input | 4 | Op class of the new micro-operation |
| al_dst | input | 7 | Newly claimed destination physical register |
| al_old | input | 7 | Physical register previously mapped to the same architectural register |
| al_tag | output | 5 | Tag (wrap bit and slot index) that the next accepted entry receives |
| cp_valid | input | 1 | Execution reports a completion |
| cp_idx | input | 4 | Slot index of the completed entry |
| cp_fault | input | 1 | Completed entry raised a fault |
| mp_valid | input | 1 | Branch misprediction reported |
| mp_tag | input | 5 | Tag of the mispredicted branch |
| rt_valid | output | 2 | Per-slot commit strobes |
| rt_old | output | 14 | Stale physical registers released by commits, 7 bits per slot |
| sq_valid | output | 2 | Per-slot discard strobes |
| sq_dst | output | 14 | Destination registers reclaimed by discards, 7 bits per slot |
| ex_valid | output | 1 | Precise fault report at the head |
| ex_pc | output | 32 | PC of the faulting entry |
| ex_op | output | 4 | Op class of the faulting entry |
| empty | output | 1 | No entries held |
| full | output | 1 | All 16 entries held |

## Verification
Several properties are checked on every cycle:
- the occupancy never goes above the depth;
- `full` and `empty` are never both set;
- a full buffer never shows `al_ready`;
- commit slot 1 never fires without slot 0;
- commit and discard never overlap;
- a fault report is followed by a blocked allocation;
- the head pointer stays put while a discard walk runs.

Other behaviour depends on the order and values of the traffic, so only the bench scenarios can show it. These are: the exact stale registers released and their order; which registers are reclaimed, youngest first; that a completed entry waits behind an incomplete head; the PC reported for a fault; and that a misprediction keeps the branch itself.

// File: rtl/rq_pkg.sv
package rq_pkg;
  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_WALK = 1'b1
  } rq_state_e;
endpackage

// File: rtl/rq_ptr_ctrl.sv
module rq_ptr_ctrl
  import rq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int RET_W = 2,
  parameter int PTR_W = 5,
  parameter int CW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic             exc_fire,
  input  logic             mp_fire,
  input  logic [PTR_W-1:0] mp_tag,
  input  logic [CW-1:0]    n_ret,
  input  logic [CW-1:0]    n_sq,
  output logic [PTR_W-1:0] head_q,
  output logic [PTR_W-1:0] tail_q,
  output logic [PTR_W-1:0] stop_q,
  output logic             walking
);
  rq_state_e st_q, st_d;
  logic [PTR_W-1:0] head_d, tail_d, stop_d;
  logic [PTR_W-1:0] remain;

  assign remain  = tail_q - stop_q;
  assign walking = (st_q == ST_WALK);

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    stop_d = stop_q;
    st_d   = st_q;
    if (st_q == ST_RUN) begin
      head_d = head_q + PTR_W'(n_ret);
      if (exc_fire) begin
        st_d   = ST_WALK;
        stop_d = head_q;
      end else if (mp_fire) begin
        st_d   = ST_WALK;
        stop_d = mp_tag + PTR_W'(1);
      end else if (alloc_fire) begin
        tail_d = tail_q + PTR_W'(1);
      end
    end else begin
      tail_d = tail_q - PTR_W'(n_sq);
      if (remain <= PTR_W'(RET_W)) st_d = ST_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      stop_q <= '0;
      st_q   <= ST_RUN;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      stop_q <= stop_d;
      st_q   <= st_d;
    end
  end

  assert_occupancy_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_q - head_q) <= PTR_W'(DEPTH))
    else $error("occupancy above depth");

  assert_head_frozen_in_walk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WALK) |=> $stable(head_q))
    else $error("head moved during discard walk");
endmodule

// File: rtl/rq_entry_store.sv
module rq_entry_store #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4,
  parameter int PC_W  = 32,
  parameter int OP_W  = 4,
  parameter int PR_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PC_W-1:0]  wr_pc,
  input  logic [OP_W-1:0]  wr_op,
  input  logic [PR_W-1:0]  wr_dst,
  input  logic [PR_W-1:0]  wr_old,
  input  logic             cp_en,
  input  logic [IDX_W-1:0] cp_idx,
  input  logic             cp_fault,
  output logic [PC_W-1:0]  pc_q   [DEPTH],
  output logic [OP_W-1:0]  op_q   [DEPTH],
  output logic [PR_W-1:0]  dst_q  [DEPTH],
  output logic [PR_W-1:0]  old_q  [DEPTH],
  output logic             done_q [DEPTH],
  output logic             flt_q  [DEPTH]
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic wr_hit, cp_hit;
    assign wr_hit = wr_en && (wr_idx == IDX_W'(i));
    assign cp_hit = cp_en && (cp_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (wr_hit) begin
        pc_q[i]  <= wr_pc;
        op_q[i]  <= wr_op;
        dst_q[i] <= wr_dst;
        old_q[i] <= wr_old;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        done_q[i] <= 1'b0;
        flt_q[i]  <= 1'b0;
      end else if (wr_hit) begin
        done_q[i] <= 1'b0;
        flt_q[i]  <= 1'b0;
      end else if (cp_hit) begin
        done_q[i] <= 1'b1;
        flt_q[i]  <= cp_fault;
      end
    end
  end
endmodule

// File: rtl/rq_retire_pick.sv
module rq_retire_pick #(
  parameter int DEPTH = 16,
  parameter int RET_W = 2,
  parameter int IDX_W = 4,
  parameter int PTR_W = 5,
  parameter int CW    = 2,
  parameter int PC_W  = 32,
  parameter int OP_W  = 4,
  parameter int PR_W  = 7
) (
  input  logic                  run,
  input  logic                  hold,
  input  logic [PTR_W-1:0]      head,
  input  logic [PTR_W-1:0]      tail,
  input  logic [PC_W-1:0]       pc_q   [DEPTH],
  input  logic [OP_W-1:0]       op_q   [DEPTH],
  input  logic [PR_W-1:0]       old_q  [DEPTH],
  input  logic                  done_q [DEPTH],
  input  logic                  flt_q  [DEPTH],
  output logic [RET_W-1:0]      rt_valid,
  output logic [RET_W*PR_W-1:0] rt_old,
  output logic [CW-1:0]         n_ret,
  output logic                  exc,
  output logic [PC_W-1:0]       exc_pc,
  output logic [OP_W-1:0]       exc_op
);
  logic [PTR_W-1:0] cnt;
  logic [IDX_W-1:0] hidx;
  logic [RET_W:0]   chain;

  assign cnt      = tail - head;
  assign hidx     = head[IDX_W-1:0];
  assign chain[0] = run & ~hold;

  for (genvar k = 0; k < RET_W; k++) begin : g_slot
    logic [IDX_W-1:0] idx;
    logic             live;
    assign idx          = IDX_W'(head + PTR_W'(k));
    assign live         = PTR_W'(k) < cnt;
    assign chain[k+1]   = chain[k] & live & done_q[idx] & ~flt_q[idx];
    assign rt_valid[k]  = chain[k+1];
    assign rt_old[k*PR_W +: PR_W] = old_q[idx];
  end

  always_comb begin
    n_ret = '0;
    for (int k = 0; k < RET_W; k++) n_ret = n_ret + CW'(rt_valid[k]);
  end

  assign exc    = run & (cnt != '0) & done_q[hidx] & flt_q[hidx];
  assign exc_pc = pc_q[hidx];
  assign exc_op = op_q[hidx];
endmodule

// File: rtl/rq_squash_pick.sv
module rq_squash_pick #(
  parameter int DEPTH = 16,
  parameter int RET_W = 2,
  parameter int IDX_W = 4,
  parameter int PTR_W = 5,
  parameter int CW    = 2,
  parameter int PR_W  = 7
) (
  input  logic                  walking,
  input  logic [PTR_W-1:0]      tail,
  input  logic [PTR_W-1:0]      stop,
  input  logic [PR_W-1:0]       dst_q [DEPTH],
  output logic [RET_W-1:0]      sq_valid,
  output logic [RET_W*PR_W-1:0] sq_dst,
  output logic [CW-1:0]         n_sq
);
  logic [PTR_W-1:0] remain;
  assign remain = tail - stop;

  for (genvar k = 0; k < RET_W; k++) begin : g_slot
    logic [IDX_W-1:0] idx;
    assign idx         = IDX_W'(tail - PTR_W'(k + 1));
    assign sq_valid[k] = walking & (PTR_W'(k) < remain);
    assign sq_dst[k*PR_W +: PR_W] = dst_q[idx];
  end

  always_comb begin
    n_sq = '0;
    for (int k = 0; k < RET_W; k++) n_sq = n_sq + CW'(sq_valid[k]);
  end
endmodule

// File: rtl/retire_queue.sv
module retire_queue #(
  parameter int DEPTH = 16,
  parameter int RET_W = 2,
  parameter int PC_W  = 32,
  parameter int OP_W  = 4,
  parameter int PR_W  = 7,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int PTR_W = IDX_W + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  al_valid,
  output logic                  al_ready,
  input  logic [PC_W-1:0]       al_pc,
  input  logic [OP_W-1:0]       al_op,
  input  logic [PR_W-1:0]       al_dst,
  input  logic [PR_W-1:0]       al_old,
  output logic [PTR_W-1:0]      al_tag,
  input  logic                  cp_valid,
  input  logic [IDX_W-1:0]      cp_idx,
  input  logic                  cp_fault,
  input  logic                  mp_valid,
  input  logic [PTR_W-1:0]      mp_tag,
  output logic [RET_W-1:0]      rt_valid,
  output logic [RET_W*PR_W-1:0] rt_old,
  output logic [RET_W-1:0]      sq_valid,
  output logic [RET_W*PR_W-1:0] sq_dst,
  output logic                  ex_valid,
  output logic [PC_W-1:0]       ex_pc,
  output logic [OP_W-1:0]       ex_op,
  output logic                  empty,
  output logic                  full
);
  localparam int CW = $clog2(RET_W + 1);

  logic [1:0] rst_sync_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  logic [PTR_W-1:0] head_q, tail_q, stop_q, cnt;
  logic             walking, alloc_fire;
  logic [CW-1:0]    n_ret, n_sq;

  logic [PC_W-1:0]  pc_q   [DEPTH];
  logic [OP_W-1:0]  op_q   [DEPTH];
  logic [PR_W-1:0]  dst_q  [DEPTH];
  logic [PR_W-1:0]  old_q  [DEPTH];
  logic             done_q [DEPTH];
  logic             flt_q  [DEPTH];

  assign cnt        = tail_q - head_q;
  assign full       = (cnt == PTR_W'(DEPTH));
  assign empty      = (cnt == '0);
  assign al_ready   = ~walking & ~ex_valid & ~mp_valid & ~full;
  assign alloc_fire = al_valid & al_ready;
  assign al_tag     = tail_q;

  rq_ptr_ctrl #(.DEPTH(DEPTH), .RET_W(RET_W), .PTR_W(PTR_W), .CW(CW)) ptr_i (
    .clk(clk), .rst_n(rst_s), .alloc_fire(alloc_fire), .exc_fire(ex_valid),
    .mp_fire(mp_valid), .mp_tag(mp_tag), .n_ret(n_ret), .n_sq(n_sq),
    .head_q(head_q), .tail_q(tail_q), .stop_q(stop_q), .walking(walking));

  rq_entry_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .PC_W(PC_W), .OP_W(OP_W), .PR_W(PR_W)) store_i (
    .clk(clk), .rst_n(rst_s), .wr_en(alloc_fire), .wr_idx(tail_q[IDX_W-1:0]),
    .wr_pc(al_pc), .wr_op(al_op), .wr_dst(al_dst), .wr_old(al_old),
    .cp_en(cp_valid), .cp_idx(cp_idx), .cp_fault(cp_fault),
    .pc_q(pc_q), .op_q(op_q), .dst_q(dst_q), .old_q(old_q), .done_q(done_q), .flt_q(flt_q));

  rq_retire_pick #(.DEPTH(DEPTH), .RET_W(RET_W), .IDX_W(IDX_W), .PTR_W(PTR_W), .CW(CW),
                   .PC_W(PC_W), .OP_W(OP_W), .PR_W(PR_W)) ret_i (
    .run(~walking), .hold(mp_valid), .head(head_q), .tail(tail_q),
    .pc_q(pc_q), .op_q(op_q), .old_q(old_q), .done_q(done_q), .flt_q(flt_q),
    .rt_valid(rt_valid), .rt_old(rt_old), .n_ret(n_ret),
    .exc(ex_valid), .exc_pc(ex_pc), .exc_op(ex_op));

  rq_squash_pick #(.DEPTH(DEPTH), .RET_W(RET_W), .IDX_W(IDX_W), .PTR_W(PTR_W), .CW(CW),
                   .PR_W(PR_W)) sq_i (
    .walking(walking), .tail(tail_q), .stop(stop_q), .dst_q(dst_q),
    .sq_valid(sq_valid), .sq_dst(sq_dst), .n_sq(n_sq));

  assert_full_refuses_R2: assert property (@(posedge clk) disable iff (!rst_s)
    full |-> !al_ready)
    else $error("ready while full");

  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_s)
    !(full && empty))
    else $error("full and empty together");

  assert_fault_blocks_alloc_R5: assert property (@(posedge clk) disable iff (!rst_s)
    ex_valid |=> !al_ready)
    else $error("allocation open after fault report");

  assert_fault_no_commit_R5: assert property (@(posedge clk) disable iff (!rst_s)
    ex_valid |-> (rt_valid == '0))
    else $error("commit alongside fault report");

  assert_discard_no_commit_R6: assert property (@(posedge clk) disable iff (!rst_s)
    (sq_valid != '0) |-> (rt_valid == '0))
    else $error("commit during discard");

  for (genvar k = 1; k < RET_W; k++) begin : g_ord
    assert_slot_order_R4: assert property (@(posedge clk) disable iff (!rst_s)
      rt_valid[k] |-> rt_valid[k-1])
      else $error("commit slot skipped");
  end
endmodule

// File: tb/retire_queue_tb_top.sv
module retire_queue_tb_top;
  localparam int PR = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        al_valid = 1'b0;
  logic        al_ready;
  logic [31:0] al_pc = '0;
  logic [3:0]  al_op = '0;
  logic [6:0]  al_dst = '0;
  logic [6:0]  al_old = '0;
  logic [4:0]  al_tag;
  logic        cp_valid = 1'b0;
  logic [3:0]  cp_idx = '0;
  logic        cp_fault = 1'b0;
  logic        mp_valid = 1'b0;
  logic [4:0]  mp_tag = '0;
  logic [1:0]  rt_valid;
  logic [13:0] rt_old;
  logic [1:0]  sq_valid;
  logic [13:0] sq_dst;
  logic        ex_valid;
  logic [31:0] ex_pc;
  logic [3:0]  ex_op;
  logic        empty, full;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] q_pc[$];
  logic [3:0]  q_op[$];
  logic [6:0]  q_dst[$];
  logic [6:0]  q_old[$];

  always #5 clk = ~clk;

  retire_queue dut_i (
    .clk(clk), .rst_n(rst_n), .al_valid(al_valid), .al_ready(al_ready), .al_pc(al_pc),
    .al_op(al_op), .al_dst(al_dst), .al_old(al_old), .al_tag(al_tag),
    .cp_valid(cp_valid), .cp_idx(cp_idx), .cp_fault(cp_fault),
    .mp_valid(mp_valid), .mp_tag(mp_tag), .rt_valid(rt_valid), .rt_old(rt_old),
    .sq_valid(sq_valid), .sq_dst(sq_dst), .ex_valid(ex_valid), .ex_pc(ex_pc),
    .ex_op(ex_op), .empty(empty), .full(full));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Scoreboard: commits pop the oldest entry, discards pop the youngest.
  always @(negedge clk) begin
    if (rst_n) begin
      if (rt_valid[1]) chk(rt_valid[0], "R4", "slot1 without slot0", rt_valid, 2'b11);
      for (int k = 0; k < 2; k++) begin
        if (rt_valid[k]) begin
          if (q_old.size() == 0) chk(1'b0, "R3", "commit with nothing held", k, 0);
          else begin
            chk(rt_old[k*PR +: PR] == q_old[0], "R3", "stale reg order", rt_old[k*PR +: PR], q_old[0]);
            void'(q_pc.pop_front()); void'(q_op.pop_front());
            void'(q_dst.pop_front()); void'(q_old.pop_front());
          end
        end
      end
      for (int k = 0; k < 2; k++) begin
        if (sq_valid[k]) begin
          if (q_dst.size() == 0) chk(1'b0, "R6", "discard with nothing held", k, 0);
          else begin
            chk(sq_dst[k*PR +: PR] == q_dst[$], "R6", "reclaimed reg", sq_dst[k*PR +: PR], q_dst[$]);
            void'(q_pc.pop_back()); void'(q_op.pop_back());
            void'(q_dst.pop_back()); void'(q_old.pop_back());
          end
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_alloc(input logic [31:0] pc, input logic [3:0] op, input logic [6:0] dst,
                          input logic [6:0] old, output logic [4:0] tag, output bit took);
    al_valid = 1'b1; al_pc = pc; al_op = op; al_dst = dst; al_old = old;
    @(negedge clk);
    tag = al_tag;
    took = al_ready;
    @(posedge clk);
    if (took) begin
      q_pc.push_back(pc); q_op.push_back(op); q_dst.push_back(dst); q_old.push_back(old);
    end
    #1 al_valid = 1'b0;
  endtask

  task automatic complete(input logic [3:0] idx, input bit flt);
    cp_valid = 1'b1; cp_idx = idx; cp_fault = flt;
    @(posedge clk); #1;
    cp_valid = 1'b0; cp_fault = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(empty == 1'b1, "R1", "empty", empty, 1);
    chk(full == 1'b0, "R1", "full", full, 0);
    chk(al_ready == 1'b1, "R1", "ready", al_ready, 1);
    chk(rt_valid == 2'b00 && sq_valid == 2'b00 && ex_valid == 1'b0, "R1", "strobes",
        {rt_valid, sq_valid, ex_valid}, 0);
    step();
  endtask

  task automatic t_fill();
    logic [4:0] tag;
    bit took;
    for (int i = 0; i < 16; i++) begin
      do_alloc(32'h1000 + 32'(i * 4), 4'(i), 7'(8 + i), 7'(40 + i), tag, took);
      chk(tag == 5'(i) && took, "R2", "tag in order", tag, i);
    end
    @(negedge clk);
    chk(full == 1'b1 && empty == 1'b0, "R7", "full flag", {full, empty}, 2'b10);
    chk(al_ready == 1'b0, "R2", "ready low when full", al_ready, 0);
    step();
    do_alloc(32'hdead, 4'h0, 7'h7f, 7'h7f, tag, took);
    @(negedge clk);
    chk(!took && al_tag == 5'h10, "R2", "refused alloc keeps tag", al_tag, 5'h10);
    chk(rt_valid == 2'b00, "R8", "nothing complete yet", rt_valid, 0);
    step();
  endtask

  task automatic t_ooo_retire();
    complete(4'd3, 1'b0);
    @(negedge clk);
    chk(rt_valid == 2'b00, "R8", "complete behind incomplete head", rt_valid, 0);
    step();
    complete(4'd0, 1'b0);
    @(negedge clk);
    chk(rt_valid == 2'b01, "R4", "slot1 blocked by incomplete entry", rt_valid, 2'b01);
    chk(rt_old[6:0] == 7'd40, "R3", "head stale reg", rt_old[6:0], 40);
    step();
    @(negedge clk);
    chk(full == 1'b0 && al_ready == 1'b1, "R7", "full clears after commit", {full, al_ready}, 2'b01);
    step();
    complete(4'd2, 1'b0);
    @(negedge clk);
    chk(rt_valid == 2'b00, "R3", "head 1 not complete", rt_valid, 0);
    step();
    complete(4'd1, 1'b0);
    @(negedge clk);
    chk(rt_valid == 2'b11, "R4", "two commits", rt_valid, 2'b11);
    chk(rt_old == {7'd42, 7'd41}, "R3", "two stale regs", rt_old, {7'd42, 7'd41});
    step();
    @(negedge clk);
    chk(rt_valid == 2'b01, "R4", "entry 3 alone", rt_valid, 2'b01);
    step();
    for (int i = 4; i < 16; i++) complete(4'(i), 1'b0);
    repeat (4) step();
    @(negedge clk);
    chk(empty == 1'b1 && q_old.size() == 0, "R3", "all committed in order", q_old.size(), 0);
    chk(al_tag == 5'h10, "R7", "wrap bit set after 16", al_tag, 5'h10);
    step();
  endtask

  task automatic t_mispredict();
    logic [4:0] tags[6];
    logic [4:0] tg;
    bit took;
    for (int i = 0; i < 6; i++) begin
      do_alloc(32'h2000 + 32'(i * 4), 4'h2, 7'(20 + i), 7'(60 + i), tags[i], took);
    end
    chk(tags[0] == 5'h10, "R7", "tag after wrap", tags[0], 5'h10);
    complete(tags[0][3:0], 1'b0);
    mp_valid = 1'b1; mp_tag = tags[2];
    @(negedge clk);
    chk(rt_valid == 2'b00, "R6", "no commit in flush cycle", rt_valid, 0);
    chk(al_ready == 1'b0, "R6", "ready low in flush cycle", al_ready, 0);
    step();
    mp_valid = 1'b0;
    @(negedge clk);
    chk(sq_valid == 2'b11 && sq_dst == {7'd24, 7'd25}, "R6", "first discard pair", sq_dst, {7'd24, 7'd25});
    chk(al_ready == 1'b0, "R6", "ready low in walk", al_ready, 0);
    step();
    @(negedge clk);
    chk(sq_valid == 2'b01 && sq_dst[6:0] == 7'd23, "R6", "last discard", sq_dst[6:0], 23);
    step();
    @(negedge clk);
    chk(sq_valid == 2'b00 && rt_valid == 2'b01 && al_ready, "R6", "branch kept, head commits",
        {sq_valid, rt_valid, al_ready}, 5'b00011);
    step();
    complete(tags[1][3:0], 1'b0);
    complete(tags[2][3:0], 1'b0);
    repeat (3) step();
    @(negedge clk);
    chk(empty == 1'b1 && q_dst.size() == 0, "R6", "drained after flush", q_dst.size(), 0);
    step();
    do_alloc(32'h3000, 4'h1, 7'd30, 7'd70, tg, took);
    do_alloc(32'h3004, 4'h1, 7'd31, 7'd71, tg, took);
    mp_valid = 1'b1; mp_tag = tg;
    step();
    mp_valid = 1'b0;
    @(negedge clk);
    chk(sq_valid == 2'b00 && q_dst.size() == 2, "R6", "youngest branch discards nothing",
        q_dst.size(), 2);
    step();
    complete(4'(tg - 5'd1), 1'b0);
    complete(tg[3:0], 1'b0);
    repeat (3) step();
    @(negedge clk);
    chk(empty == 1'b1, "R3", "drained", empty, 1);
    step();
  endtask

  task automatic t_fault();
    logic [4:0] tags[4];
    bit took;
    for (int i = 0; i < 4; i++) begin
      do_alloc(32'h4000 + 32'(i * 4), 4'(5 + i), 7'(90 + i), 7'(100 + i), tags[i], took);
    end
    complete(tags[1][3:0], 1'b1);
    complete(tags[2][3:0], 1'b0);
    complete(tags[3][3:0], 1'b0);
    complete(tags[0][3:0], 1'b0);
    @(negedge clk);
    chk(rt_valid == 2'b01 && ex_valid == 1'b0, "R5", "commit stops before fault",
        {rt_valid, ex_valid}, 3'b010);
    step();
    @(negedge clk);
    chk(ex_valid == 1'b1, "R5", "fault reported", ex_valid, 1);
    chk(ex_pc == 32'h4004 && ex_op == 4'd6, "R5", "fault pc and op", {ex_op, ex_pc}, {4'd6, 32'h4004});
    chk(rt_valid == 2'b00, "R5", "faulting entry not committed", rt_valid, 0);
    step();
    @(negedge clk);
    chk(sq_valid == 2'b11 && sq_dst == {7'd92, 7'd93}, "R5", "discard pair", sq_dst, {7'd92, 7'd93});
    step();
    @(negedge clk);
    chk(sq_valid == 2'b01 && sq_dst[6:0] == 7'd91, "R5", "faulting entry reclaimed", sq_dst[6:0], 91);
    step();
    @(negedge clk);
    chk(empty && al_ready && ex_valid == 1'b0 && q_dst.size() == 0, "R5", "empty after fault flush",
        {empty, al_ready, ex_valid}, 3'b110);
    step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) step();
    t_reset();
    t_fill();
    t_ooo_retire();
    t_mispredict();
    t_fault();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule